// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Check

This block is a small single-accumulator processor that works on 16-bit words. Every instruction is read from a word-addressed memory port in a fetch phase and then carried out in an execute phase. Each memory access goes through an internal address holding register and an internal data holding register. The data holding register drives the write data pins and captures the read data. The accumulator can be loaded from memory, stored to memory, and added to a memory word. Addition works on sign-magnitude integers.

After each instruction the processor checks whether an interrupt request is pending. If one is pending and interrupts are enabled, it writes the return program counter to a fixed save word, turns interrupts off and continues at a fixed handler address. A return instruction reads the save word back into the program counter and turns interrupts on again. A request that arrives while interrupts are off is held and is taken after the return. The processor is meant for small control tasks and for exercising a memory model. Its status pins show the halt state, a sticky overflow flag, the interrupt enable and the accumulator.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word has its opcode in bits 15:12 and its memory address in bits 11:0. Reset sets the program counter to 0x010 and the accumulator to zero, enables interrupts, and clears halted and overflow. During reset neither memory strobe is asserted.
- R2: A fetch asserts mem_rd with mem_addr equal to the program counter, and the read data is taken one cycle after the strobe. The program counter then advances by one, so the first read after reset is at 0x010.
- R3: Opcode 0x1 loads the accumulator from the addressed word. It issues a single read and no write.
- R4: Opcode 0x2 asserts mem_wr once, with mem_addr equal to the address field and mem_wdata equal to the accumulator.
- R5: Opcode 0x5 adds the addressed word to the accumulator. Bit 15 is the sign and bits 14:0 are the magnitude. With equal signs the magnitudes are added. With differing signs the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger. A zero result is always +0.
- R6: An add whose magnitude sum exceeds 0x7FFF keeps the low 15 bits of the sum and sets overflow. Overflow stays set until reset.
- R7: Opcode 0x0 raises halted. After that no memory strobe is asserted, and halted holds until reset.
- R8: Any opcode other than 0x0, 0x1, 0x2, 0x5 and 0xF makes no data access and leaves the accumulator unchanged.
- R9: After each instruction, a pending request with interrupts enabled causes the following. The return program counter, zero-extended, is written to word 0. Interrupts are disabled. The next fetch is from word 1.
- R10: Opcode 0xF reads word 0, loads its low 12 bits into the program counter and re-enables interrupts, so the interrupted program resumes with its result intact.
- R11: A request that arrives while interrupts are disabled stays pending and is serviced after the return. A request in the same cycle as an acceptance also stays pending.
- R12: mem_rd and mem_wr are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Word address from the address holding register |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data from the data holding register |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| irq_req | input | 1 | Interrupt request, sampled on each clock |
| halted | output | 1 | High once a halt opcode has executed |
| overflow | output | 1 | Sticky sign-magnitude overflow flag |
| int_en | output | 1 | Interrupt enable state |
| acc_out | output | 16 | Accumulator value |

## Verification
Two events can fall in the same cycle: the pending latch being cleared because the interrupt check accepts it, and a new request arriving. The bench provokes this by sliding a two-cycle request pulse across every start cycle of a short program. Each accepted interrupt shows up at the ports as a write to word 0. The bench counts the handler entries: it expects two when the first save write comes exactly two cycles after the pulse starts, and one otherwise. It also checks that at least one offset hit the coincidence and that the program's sum is unaffected.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [3:0] {
        S_FETCH_A,
        S_FETCH_R,
        S_FETCH_W,
        S_DECODE,
        S_RD_REQ,
        S_RD_CAP,
        S_EXEC,
        S_WR,
        S_ICHK,
        S_SAVE,
        S_HALT
    } state_e;

    localparam logic [3:0] OP_HALT  = 4'h0;
    localparam logic [3:0] OP_LOAD  = 4'h1;
    localparam logic [3:0] OP_STORE = 4'h2;
    localparam logic [3:0] OP_ADD   = 4'h5;
    localparam logic [3:0] OP_RET   = 4'hF;

endpackage

// File: rtl/acc_sm_add.sv
module acc_sm_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         ovf
);
    localparam int MW = W - 1;

    logic [MW-1:0] mag_a, mag_b, mag_r;
    logic [MW:0]   tot;
    logic          sgn_r;

    always_comb begin
        mag_a = a[MW-1:0];
        mag_b = b[MW-1:0];
        tot   = {1'b0, mag_a} + {1'b0, mag_b};
        ovf   = 1'b0;
        if (a[W-1] == b[W-1]) begin
            mag_r = tot[MW-1:0];
            ovf   = tot[MW];
            sgn_r = a[W-1];
        end else if (mag_a >= mag_b) begin
            mag_r = mag_a - mag_b;
            sgn_r = a[W-1];
        end else begin
            mag_r = mag_b - mag_a;
            sgn_r = b[W-1];
        end
        if (mag_r == '0) sgn_r = 1'b0;
        sum = {sgn_r, mag_r};
    end

    // opposite operands of equal size must cancel to +0
    always_comb begin
        if (a[W-1] != b[W-1] && a[MW-1:0] == b[MW-1:0]) begin
            AST_CANCEL_POS_ZERO: assert (sum == '0 && !ovf); // R5
        end
    end

endmodule

// File: rtl/acc_irq_pend.sv
module acc_irq_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic take,
    output logic pend
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = (pend_q & ~take) | req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> pend); // R11
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req) |=> !pend); // R9

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu #(
    parameter int                DW         = 16,
    parameter int                AW         = 12,
    parameter logic [AW-1:0]     RESET_PC   = 12'h010,
    parameter logic [AW-1:0]     HANDLER_PC = 12'h001,
    parameter logic [AW-1:0]     SAVE_ADDR  = 12'h000
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          irq_req,
    output logic          halted,
    output logic          overflow,
    output logic          int_en,
    output logic [DW-1:0] acc_out
);
    import acc_pkg::*;

    localparam int OPW = DW - AW;

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] pc;
        logic [AW-1:0] mar;
        logic [DW-1:0] mbr;
        logic [DW-1:0] ir;
        logic [DW-1:0] ac;
        logic          ie;
        logic          ovf;
    } core_t;

    core_t q, d;

    logic [OPW-1:0] op;
    logic [AW-1:0]  fld;
    logic [DW-1:0]  add_sum;
    logic           add_ovf;
    logic           pend, take;

    assign op  = q.ir[DW-1 -: OPW];
    assign fld = q.ir[AW-1:0];

    acc_sm_add #(.W(DW)) u_add (
        .a   (q.ac),
        .b   (q.mbr),
        .sum (add_sum),
        .ovf (add_ovf)
    );

    acc_irq_pend u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_req),
        .take  (take),
        .pend  (pend)
    );

    always_comb begin
        d      = q;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        take   = 1'b0;
        case (q.st)
            S_FETCH_A: begin
                d.mar = q.pc;
                d.st  = S_FETCH_R;
            end
            S_FETCH_R: begin
                mem_rd = 1'b1;
                d.st   = S_FETCH_W;
            end
            S_FETCH_W: begin
                d.ir  = mem_rdata;
                d.mbr = mem_rdata;
                d.pc  = q.pc + 1'b1;
                d.st  = S_DECODE;
            end
            S_DECODE: begin
                case (op)
                    OP_HALT: d.st = S_HALT;
                    OP_LOAD, OP_ADD: begin
                        d.mar = fld;
                        d.st  = S_RD_REQ;
                    end
                    OP_STORE: begin
                        d.mar = fld;
                        d.mbr = q.ac;
                        d.st  = S_WR;
                    end
                    OP_RET: begin
                        d.mar = SAVE_ADDR;
                        d.st  = S_RD_REQ;
                    end
                    default: d.st = S_ICHK;
                endcase
            end
            S_RD_REQ: begin
                mem_rd = 1'b1;
                d.st   = S_RD_CAP;
            end
            S_RD_CAP: begin
                d.mbr = mem_rdata;
                d.st  = S_EXEC;
            end
            S_EXEC: begin
                case (op)
                    OP_LOAD: d.ac = q.mbr;
                    OP_ADD: begin
                        d.ac  = add_sum;
                        d.ovf = q.ovf | add_ovf;
                    end
                    OP_RET: begin
                        d.pc = q.mbr[AW-1:0];
                        d.ie = 1'b1;
                    end
                    default: ;
                endcase
                d.st = S_ICHK;
            end
            S_WR: begin
                mem_wr = 1'b1;
                d.st   = S_ICHK;
            end
            S_ICHK: begin
                if (pend && q.ie) begin
                    take  = 1'b1;
                    d.mar = SAVE_ADDR;
                    d.mbr = {{(DW-AW){1'b0}}, q.pc};
                    d.pc  = HANDLER_PC;
                    d.ie  = 1'b0;
                    d.st  = S_SAVE;
                end else begin
                    d.st  = S_FETCH_A;
                end
            end
            S_SAVE: begin
                mem_wr = 1'b1;
                d.st   = S_FETCH_A;
            end
            S_HALT:  d.st = S_HALT;
            default: d.st = S_FETCH_A;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= S_FETCH_A;
            q.pc  <= RESET_PC;
            q.mar <= '0;
            q.mbr <= '0;
            q.ir  <= '0;
            q.ac  <= '0;
            q.ie  <= 1'b1;
            q.ovf <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr  = q.mar;
    assign mem_wdata = q.mbr;
    assign halted    = (q.st == S_HALT);
    assign overflow  = q.ovf;
    assign int_en    = q.ie;
    assign acc_out   = q.ac;

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R12
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr)); // R7
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R6
    AST_SAVE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SAVE) |-> (mem_wr && mem_addr == SAVE_ADDR && !int_en)); // R9
    AST_SAVE_THEN_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SAVE) |=> ##1 (mem_rd && mem_addr == HANDLER_PC)); // R9

endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        irq_req;
    logic        halted, overflow, int_en;
    logic [15:0] acc_out;

    always #10 clk = ~clk;

    acc_cpu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .irq_req   (irq_req),
        .halted    (halted),
        .overflow  (overflow),
        .int_en    (int_en),
        .acc_out   (acc_out)
    );

    logic [15:0] mem [0:4095];
    logic        ld_en;
    logic [11:0] ld_addr;
    logic [15:0] ld_data;

    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr]  <= ld_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd)      mem_rdata     <= mem[mem_addr];
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
        $finish;
    end

    task automatic poke(input logic [11:0] a, input logic [15:0] v);
        ld_en = 1'b1; ld_addr = a; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic begin_load();
        @(negedge clk);
        rst_n = 1'b0;
        irq_req = 1'b0;
    endtask

    task automatic release_rst();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // run state
    int r_saves, r_first_save, r_rd, r_wr, r_post, r_first_rd, r_halt_at;
    logic r_ie_mid;

    task automatic run(input int p1, input int p1len, input int p2gap, input int limit);
        bit exp_h;
        r_saves = 0; r_first_save = -1; r_rd = 0; r_wr = 0; r_post = 0;
        r_first_rd = -1; r_halt_at = -1; exp_h = 0; r_ie_mid = 1'b1;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (r_halt_at >= 0) begin
                if (mem_rd || mem_wr) r_post++;
                if (!halted) r_post++;
                if (k >= r_halt_at + 8) break;
            end else begin
                if (mem_rd) begin
                    r_rd++;
                    if (r_first_rd < 0) r_first_rd = int'(mem_addr);
                    if (exp_h) begin
                        chk(mem_addr == 12'h001, "R9 handler fetch", int'(mem_addr), 1);
                        exp_h = 0;
                    end
                end
                if (mem_wr) begin
                    r_wr++;
                    if (mem_addr == 12'h000) begin
                        r_saves++;
                        if (r_first_save < 0) r_first_save = k;
                        exp_h = 1;
                    end
                end
                if (halted) r_halt_at = k;
            end
            if (p2gap >= 0 && r_first_save >= 0 && k == r_first_save + p2gap)
                r_ie_mid = int_en;
            irq_req = (p1 >= 0 && k >= p1 && k < p1 + p1len) ||
                      (p2gap >= 0 && r_first_save >= 0 && k == r_first_save + p2gap);
        end
        irq_req = 1'b0;
        chk(r_halt_at >= 0, "R7 program reached halt", r_halt_at, 0);
        chk(r_post == 0, "R7 quiet and held after halt", r_post, 0);
    endtask

    function automatic logic [16:0] ref_add(input logic [15:0] a, input logic [15:0] b);
        int va, vb, s, m;
        logic sg, ov;
        va = a[15] ? -int'(a[14:0]) : int'(a[14:0]);
        vb = b[15] ? -int'(b[14:0]) : int'(b[14:0]);
        s  = va + vb;
        sg = (s < 0);
        m  = sg ? -s : s;
        ov = (m > 32767);
        m  = m % 32768;
        if (m == 0) sg = 1'b0;
        return {ov, sg, m[14:0]};
    endfunction

    logic [15:0] vals [10] = '{16'h0000, 16'h8000, 16'h0001, 16'h8001, 16'h7FFF,
                               16'hFFFF, 16'h4000, 16'hC000, 16'h1234, 16'h9234};

    initial begin
        int hits;
        logic [16:0] e;
        rst_n = 1'b0; irq_req = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        hits = 0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(halted == 1'b0, "R1 halted at reset", int'(halted), 0);
        chk(overflow == 1'b0, "R1 overflow at reset", int'(overflow), 0);
        chk(int_en == 1'b1, "R1 int_en at reset", int'(int_en), 1);
        chk(acc_out == 16'h0, "R1 acc at reset", int'(acc_out), 0);
        chk(!mem_rd && !mem_wr, "R1 no strobe in reset", int'({mem_rd, mem_wr}), 0);

        // R3 R4 R5 R6 sweep over all operand pairs
        for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 10; j++) begin
                begin_load();
                poke(12'h010, 16'h1100);
                poke(12'h011, 16'h5101);
                poke(12'h012, 16'h2102);
                poke(12'h013, 16'h0000);
                poke(12'h100, vals[i]);
                poke(12'h101, vals[j]);
                poke(12'h102, 16'hDEAD);
                release_rst();
                run(-1, 0, -1, 200);
                e = ref_add(vals[i], vals[j]);
                chk(acc_out == e[15:0], "R5 sign-magnitude sum", int'(acc_out), int'(e[15:0]));
                chk(mem[12'h102] == e[15:0], "R4 stored word", int'(mem[12'h102]), int'(e[15:0]));
                chk(overflow == e[16], "R6 overflow flag", int'(overflow), int'(e[16]));
                chk(r_rd == 6 && r_wr == 1, "R3 access count", r_rd * 16 + r_wr, 6 * 16 + 1);
                chk(r_first_rd == 16, "R2 first fetch address", r_first_rd, 16);
                chk(halted == 1'b1, "R7 halted", int'(halted), 1);
            end
        end

        // R6 sticky overflow across a later non-overflowing add
        begin_load();
        poke(12'h010, 16'h1100); poke(12'h011, 16'h5100); poke(12'h012, 16'h5101);
        poke(12'h013, 16'h2102); poke(12'h014, 16'h0000);
        poke(12'h100, 16'h7FFF); poke(12'h101, 16'h8001); poke(12'h102, 16'hDEAD);
        release_rst();
        run(-1, 0, -1, 300);
        chk(mem[12'h102] == 16'h7FFD, "R6 wrapped result", int'(mem[12'h102]), 16'h7FFD);
        chk(overflow == 1'b1, "R6 overflow sticky", int'(overflow), 1);

        // R8 undefined opcodes are no-ops
        begin_load();
        poke(12'h010, 16'h1100); poke(12'h011, 16'h7123); poke(12'h012, 16'h3123);
        poke(12'h013, 16'hE123); poke(12'h014, 16'h2102); poke(12'h015, 16'h0000);
        poke(12'h100, 16'h8ABC); poke(12'h102, 16'hDEAD); poke(12'h123, 16'hBEEF);
        release_rst();
        run(-1, 0, -1, 300);
        chk(mem[12'h102] == 16'h8ABC, "R8 accumulator unchanged", int'(mem[12'h102]), 16'h8ABC);
        chk(mem[12'h123] == 16'hBEEF, "R8 no write to operand", int'(mem[12'h123]), 16'hBEEF);
        chk(r_rd == 7 && r_wr == 1, "R8 no data access", r_rd * 16 + r_wr, 7 * 16 + 1);

        // R9 R10 R11 sliding two-cycle request over the program
        for (int off = 0; off <= 30; off++) begin
            begin_load();
            poke(12'h001, 16'h2101); poke(12'h002, 16'hF000);
            poke(12'h010, 16'h1200); poke(12'h011, 16'h5201); poke(12'h012, 16'h5201);
            poke(12'h013, 16'h5201); poke(12'h014, 16'h2202); poke(12'h015, 16'h0000);
            poke(12'h200, 16'h0003); poke(12'h201, 16'h0002); poke(12'h202, 16'hDEAD);
            release_rst();
            run(off, 2, -1, 600);
            if (r_first_save == off + 2) hits++;
            chk(r_saves == ((r_first_save == off + 2) ? 2 : 1), "R11 handler entries",
                r_saves, (r_first_save == off + 2) ? 2 : 1);
            chk(mem[12'h202] == 16'h0009, "R10 resumed result", int'(mem[12'h202]), 9);
            chk(int_en == 1'b1, "R10 interrupts re-enabled", int'(int_en), 1);
        end
        chk(hits > 0, "R11 coincident request observed", hits, 1);

        // R11 request during handler is held until return
        begin_load();
        poke(12'h001, 16'h2101); poke(12'h002, 16'hF000);
        poke(12'h010, 16'h1200); poke(12'h011, 16'h5201); poke(12'h012, 16'h5201);
        poke(12'h013, 16'h5201); poke(12'h014, 16'h2202); poke(12'h015, 16'h0000);
        poke(12'h200, 16'h0003); poke(12'h201, 16'h0002); poke(12'h202, 16'hDEAD);
        release_rst();
        run(4, 1, 2, 600);
        chk(r_ie_mid == 1'b0, "R9 disabled inside handler", int'(r_ie_mid), 0);
        chk(r_saves == 2, "R11 held request serviced", r_saves, 2);
        chk(mem[12'h202] == 16'h0009, "R10 result after two entries", int'(mem[12'h202]), 9);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule